// File: doc/BRIEF.md
# Split 64-bit Time Base Counter

The block keeps a free-running 64-bit unsigned count that software sees as two 32-bit registers, an upper half and a lower half. The count advances by one on each qualified tick. A tick is a rising edge of one of two external tick sources, selected by a control bit. Each source is brought into the core clock domain by a synchroniser before its edge is detected. A global enable bit gates counting. When the enable is clear, the value holds.

Software reaches the halves through a register-number port. Reads are open to any privilege level. Writes are taken only in supervisor mode. A user-mode write to a counter register leaves the count alone and raises a one-cycle privilege-violation pulse. The count has no power-on initial value, so software must load it. A soft reset leaves the count untouched.

The full 64-bit value and a pulse on every carry out of the lower half are also exposed for use by neighbouring timers.

Top module: `tbase_split_counter`

## Requirements
- R1: While `tb_enable` is 0, no tick changes the count. The value holds unless a supervisor write targets it.
- R2: `clk_sel` = 0 selects `tick_src_a` and `clk_sel` = 1 selects `tick_src_b`. The unselected source has no effect. Each selected source passes through a two-flop synchroniser. A rising edge on the selected source produces exactly one increment, however long the source stays high. That increment takes effect on the third rising clock edge after the source goes high.
- R3: Each qualified tick adds exactly 1 to the 64-bit unsigned value `{upper, lower}`.
- R4: When a tick arrives while the lower half is 0xFFFF_FFFF, the lower half becomes 0 and the upper half increments on the same edge. `lo_wrap` is then high for exactly the one following cycle.
- R5: A tick from 0xFFFF_FFFF_FFFF_FFFF wraps both halves to 0. No output other than the `lo_wrap` pulse indicates this.
- R6: With `reg_rd` = 1, `reg_rdata` returns in the same cycle the lower half for number 268 and the upper half for number 269. It returns 0 for any other number, and 0 while `reg_rd` = 0. A read never changes counting.
- R7: When `reg_wr` = 1 and `super_mode` = 1, number 284 loads `reg_wdata` into the lower half and number 285 loads it into the upper half, at the next edge. A write to any other number, including 268 and 269, is ignored.
- R8: When `reg_wr` = 1 and `super_mode` = 0, a write to 284 or 285 leaves the count unchanged and sets `priv_viol` high for exactly the next cycle. `priv_viol` is otherwise 0.
- R9: When a write and a tick fall on the same edge, the written half takes the written value. The other half still takes the tick's effect, including a carry produced by the old lower half.
- R10: While `soft_rst_n` = 0, the count is unchanged and ticks and writes are ignored. The synchroniser and edge detector clear, and `priv_viol` and `lo_wrap` are 0. After release, the count reads as it did before the reset.
- R11: `tb_value` always equals `{upper, lower}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| soft_rst_n | input | 1 | Soft reset, active low; preserves the count |
| tb_enable | input | 1 | Counting enable |
| clk_sel | input | 1 | Tick source select (0: a, 1: b) |
| tick_src_a | input | 1 | Asynchronous tick source a |
| tick_src_b | input | 1 | Asynchronous tick source b |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_num | input | 10 | Register number |
| reg_wdata | input | 32 | Write data |
| super_mode | input | 1 | Supervisor privilege level |
| reg_rdata | output | 32 | Read data (combinational) |
| priv_viol | output | 1 | One-cycle pulse on a user-mode counter write |
| tb_value | output | 64 | Full count |
| lo_wrap | output | 1 | One-cycle pulse after a carry out of the lower half |

## Verification
Each result arrives at a fixed cycle offset from its stimulus:

- **Reads** are combinational. The scoreboard monitor samples `reg_rdata` a quarter period after the driver raises `reg_rd`, in the same cycle.
- **Writes** land on the next edge. `priv_viol` is sampled on the falling edge after that edge, and again one cycle later to confirm it has dropped.
- **Ticks** take effect on the third edge after a source rises. The bench samples `lo_wrap` and the carried value on the falling edge just after that third edge, and checks that the pulse has gone one cycle later.
- **Collisions** are built by placing a write exactly on that third edge.

// File: rtl/tbase_split_counter.sv
module tbase_split_counter #(
  parameter int HALF_W      = 32,
  parameter int NUM_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RD_LO       = 268,
  parameter int RD_HI       = 269,
  parameter int WR_LO       = 284,
  parameter int WR_HI       = 285
) (
  input  logic                clk,
  input  logic                soft_rst_n,
  input  logic                tb_enable,
  input  logic                clk_sel,
  input  logic                tick_src_a,
  input  logic                tick_src_b,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic [NUM_W-1:0]    reg_num,
  input  logic [HALF_W-1:0]   reg_wdata,
  input  logic                super_mode,
  output logic [HALF_W-1:0]   reg_rdata,
  output logic                priv_viol,
  output logic [2*HALF_W-1:0] tb_value,
  output logic                lo_wrap
);
  localparam logic [HALF_W-1:0] ALL_ONES = '1;

  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic edge_prev;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;

  always_ff @(posedge clk) begin
    if (!soft_rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      edge_prev <= 1'b0;
    end else begin
      sync_a[0] <= tick_src_a;
      sync_b[0] <= tick_src_b;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_a[i] <= sync_a[i-1];
        sync_b[i] <= sync_b[i-1];
      end
      edge_prev <= clk_sel ? sync_b[SYNC_STAGES-1] : sync_a[SYNC_STAGES-1];
    end
  end

  wire sel_lvl  = clk_sel ? sync_b[SYNC_STAGES-1] : sync_a[SYNC_STAGES-1];
  wire adv      = soft_rst_n & tb_enable & sel_lvl & ~edge_prev;
  wire lo_carry = adv & (cnt_lo == ALL_ONES);

  wire hit_wr_lo = reg_wr & (reg_num == NUM_W'(WR_LO));
  wire hit_wr_hi = reg_wr & (reg_num == NUM_W'(WR_HI));
  wire wr_ok     = soft_rst_n & super_mode;
  wire wr_bad    = soft_rst_n & ~super_mode & (hit_wr_lo | hit_wr_hi);

  always_ff @(posedge clk) begin
    if (hit_wr_lo && wr_ok)      cnt_lo <= reg_wdata;
    else if (adv)                cnt_lo <= cnt_lo + 1'b1;
    if (hit_wr_hi && wr_ok)      cnt_hi <= reg_wdata;
    else if (lo_carry)           cnt_hi <= cnt_hi + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!soft_rst_n) begin
      priv_viol <= 1'b0;
      lo_wrap   <= 1'b0;
    end else begin
      priv_viol <= wr_bad;
      lo_wrap   <= lo_carry;
    end
  end

  assign reg_rdata = !reg_rd                       ? '0 :
                     (reg_num == NUM_W'(RD_LO))    ? cnt_lo :
                     (reg_num == NUM_W'(RD_HI))    ? cnt_hi : '0;
  assign tb_value  = {cnt_hi, cnt_lo};
endmodule

// File: rtl/tbase_split_counter_chk.sv
module tbase_split_counter_chk #(
  parameter int HALF_W = 32,
  parameter int NUM_W  = 10,
  parameter int RD_LO  = 268,
  parameter int WR_LO  = 284,
  parameter int WR_HI  = 285
) (
  input logic                clk,
  input logic                soft_rst_n,
  input logic                tb_enable,
  input logic                reg_rd,
  input logic                reg_wr,
  input logic [NUM_W-1:0]    reg_num,
  input logic [HALF_W-1:0]   reg_wdata,
  input logic                super_mode,
  input logic [HALF_W-1:0]   reg_rdata,
  input logic                priv_viol,
  input logic [2*HALF_W-1:0] tb_value,
  input logic                lo_wrap
);
  wire sup_wr  = reg_wr & super_mode;
  wire ctr_num = (reg_num == NUM_W'(WR_LO)) || (reg_num == NUM_W'(WR_HI));

  // R1
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (!tb_enable && !sup_wr) |=> $stable(tb_value));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!soft_rst_n)
    !sup_wr |=> (tb_value == $past(tb_value) || tb_value == $past(tb_value) + 1'b1));

  // R4
  wrap_low_chk: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (lo_wrap && !$past(sup_wr)) |-> tb_value[HALF_W-1:0] == '0);

  // R6
  read_low_chk: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (reg_rd && reg_num == NUM_W'(RD_LO)) |-> reg_rdata == tb_value[HALF_W-1:0]);

  // R7
  sup_write_chk: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (sup_wr && reg_num == NUM_W'(WR_LO)) |=> tb_value[HALF_W-1:0] == $past(reg_wdata));

  // R8
  user_write_chk: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (reg_wr && !super_mode && ctr_num) |=> priv_viol);

  // R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (!soft_rst_n)
    priv_viol |-> $past(reg_wr && !super_mode && ctr_num));
endmodule

bind tbase_split_counter tbase_split_counter_chk #(
  .HALF_W(HALF_W), .NUM_W(NUM_W), .RD_LO(RD_LO), .WR_LO(WR_LO), .WR_HI(WR_HI)
) u_chk (
  .clk(clk), .soft_rst_n(soft_rst_n), .tb_enable(tb_enable), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_num(reg_num), .reg_wdata(reg_wdata), .super_mode(super_mode),
  .reg_rdata(reg_rdata), .priv_viol(priv_viol), .tb_value(tb_value), .lo_wrap(lo_wrap)
);

// File: tb/tb_tbase_split_counter.sv
module tb_tbase_split_counter;
  logic clk = 1'b0;
  logic soft_rst_n = 1'b0, tb_enable = 1'b0, clk_sel = 1'b0;
  logic tick_src_a = 1'b0, tick_src_b = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0, super_mode = 1'b0;
  logic [9:0]  reg_num = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        priv_viol, lo_wrap;
  logic [63:0] tb_value;

  int n_tests = 0, n_fail = 0;

  typedef struct { string tag; logic [31:0] exp; } sb_item_t;
  sb_item_t sb_q[$];
  sb_item_t cur;

  always #10 clk = ~clk;

  tbase_split_counter dut (
    .clk(clk), .soft_rst_n(soft_rst_n), .tb_enable(tb_enable), .clk_sel(clk_sel),
    .tick_src_a(tick_src_a), .tick_src_b(tick_src_b), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_num(reg_num), .reg_wdata(reg_wdata), .super_mode(super_mode),
    .reg_rdata(reg_rdata), .priv_viol(priv_viol), .tb_value(tb_value), .lo_wrap(lo_wrap)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (reg_rd) begin
      if (sb_q.size() == 0) check(1'b0, "R6 unexpected read", {32'h0, reg_rdata}, 64'h0);
      else begin
        cur = sb_q.pop_front();
        check(reg_rdata === cur.exp, cur.tag, {32'h0, reg_rdata}, {32'h0, cur.exp});
      end
    end
  end

  task automatic rd(input int num, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_num = 10'(num);
    sb_q.push_back('{tag, exp});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input int num, input logic [31:0] data, input bit sup);
    @(negedge clk);
    reg_wr = 1'b1; reg_num = 10'(num); reg_wdata = data; super_mode = sup;
    @(negedge clk);
    reg_wr = 1'b0; super_mode = 1'b0;
  endtask

  task automatic set64(input logic [63:0] v);
    wr(284, v[31:0], 1'b1);
    wr(285, v[63:32], 1'b1);
  endtask

  task automatic pulse(input bit use_b, input int hi_cycles);
    @(negedge clk);
    if (use_b) tick_src_b = 1'b1; else tick_src_a = 1'b1;
    repeat (hi_cycles) @(negedge clk);
    tick_src_a = 1'b0; tick_src_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick_watch(input logic [63:0] exp_val, input bit exp_wrap, input string tag);
    @(negedge clk); tick_src_a = 1'b1;
    repeat (3) @(negedge clk);
    check(lo_wrap === exp_wrap, {tag, " lo_wrap"}, {63'h0, lo_wrap}, {63'h0, exp_wrap});
    check(tb_value === exp_val, {tag, " value"}, tb_value, exp_val);
    tick_src_a = 1'b0;
    @(negedge clk);
    check(lo_wrap === 1'b0, {tag, " lo_wrap drop"}, {63'h0, lo_wrap}, 64'h0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state of the pulse outputs
    check(priv_viol === 1'b0 && lo_wrap === 1'b0, "R10 reset outputs", {62'h0, priv_viol, lo_wrap}, 64'h0);
    soft_rst_n = 1'b1;
    @(negedge clk);

    // R7 R6 R11 load and read back
    set64(64'h0000_00AB_1234_5678);
    rd(268, 32'h1234_5678, "R6 read low");
    rd(269, 32'h0000_00AB, "R6 read high");
    rd(300, 32'h0, "R6 unknown number");
    check(tb_value === 64'h0000_00AB_1234_5678, "R11 full value", tb_value, 64'h0000_00AB_1234_5678);
    wr(268, 32'hDEAD_BEEF, 1'b1);
    check(tb_value === 64'h0000_00AB_1234_5678, "R7 write to read number ignored", tb_value, 64'h0000_00AB_1234_5678);

    // R1 enable off holds
    pulse(1'b0, 2);
    check(tb_value === 64'h0000_00AB_1234_5678, "R1 hold while disabled", tb_value, 64'h0000_00AB_1234_5678);

    // R3 single increment
    tb_enable = 1'b1;
    pulse(1'b0, 2);
    check(tb_value === 64'h0000_00AB_1234_5679, "R3 one tick", tb_value, 64'h0000_00AB_1234_5679);

    // R2 long pulse gives one increment; unselected source ignored; select b
    pulse(1'b0, 20);
    check(tb_value === 64'h0000_00AB_1234_567A, "R2 long pulse one step", tb_value, 64'h0000_00AB_1234_567A);
    pulse(1'b1, 2);
    check(tb_value === 64'h0000_00AB_1234_567A, "R2 unselected source", tb_value, 64'h0000_00AB_1234_567A);
    clk_sel = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1'b1, 2);
    check(tb_value === 64'h0000_00AB_1234_567B, "R2 source b selected", tb_value, 64'h0000_00AB_1234_567B);
    pulse(1'b0, 2);
    check(tb_value === 64'h0000_00AB_1234_567B, "R2 source a unselected", tb_value, 64'h0000_00AB_1234_567B);
    clk_sel = 1'b0;
    repeat (3) @(negedge clk);

    // R6 read held across a tick does not disturb counting
    @(negedge clk); reg_rd = 1'b1; reg_num = 10'd269;
    repeat (2) begin sb_q.push_back('{"R6 read during tick", 32'h0000_00AB}); @(negedge clk); end
    tick_src_a = 1'b1;
    repeat (4) begin sb_q.push_back('{"R6 read during tick", 32'h0000_00AB}); @(negedge clk); end
    reg_rd = 1'b0; tick_src_a = 1'b0;
    repeat (3) @(negedge clk);
    check(tb_value === 64'h0000_00AB_1234_567C, "R6 tick kept during read", tb_value, 64'h0000_00AB_1234_567C);

    // R4 carry into upper half
    set64(64'h0000_0007_FFFF_FFFF);
    tick_watch(64'h0000_0008_0000_0000, 1'b1, "R4 carry");
    tick_watch(64'h0000_0008_0000_0001, 1'b0, "R3 no wrap");

    // R5 full wrap
    set64(64'hFFFF_FFFF_FFFF_FFFF);
    tick_watch(64'h0, 1'b1, "R5 full wrap");
    check(priv_viol === 1'b0, "R5 no other indication", {63'h0, priv_viol}, 64'h0);

    // R8 user write rejected
    set64(64'h0000_0011_0000_0022);
    tb_enable = 1'b0;
    @(negedge clk);
    reg_wr = 1'b1; reg_num = 10'd284; reg_wdata = 32'h5555_5555; super_mode = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
    check(priv_viol === 1'b1, "R8 fault pulse", {63'h0, priv_viol}, 64'h1);
    check(tb_value === 64'h0000_0011_0000_0022, "R8 count unchanged", tb_value, 64'h0000_0011_0000_0022);
    @(negedge clk);
    check(priv_viol === 1'b0, "R8 fault one cycle", {63'h0, priv_viol}, 64'h0);
    wr(285, 32'h6666_6666, 1'b0);
    check(tb_value === 64'h0000_0011_0000_0022, "R8 upper unchanged", tb_value, 64'h0000_0011_0000_0022);
    tb_enable = 1'b1;

    // R9 write low collides with carrying tick
    set64(64'h0000_0005_FFFF_FFFF);
    @(negedge clk); tick_src_a = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_num = 10'd284; reg_wdata = 32'h100; super_mode = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; super_mode = 1'b0; tick_src_a = 1'b0;
    check(tb_value === 64'h0000_0006_0000_0100, "R9 low write with carry", tb_value, 64'h0000_0006_0000_0100);
    repeat (3) @(negedge clk);

    // R9 write high collides with tick
    set64(64'h0000_0001_0000_0005);
    @(negedge clk); tick_src_a = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_num = 10'd285; reg_wdata = 32'h77; super_mode = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; super_mode = 1'b0; tick_src_a = 1'b0;
    check(tb_value === 64'h0000_0077_0000_0006, "R9 high write with tick", tb_value, 64'h0000_0077_0000_0006);
    repeat (3) @(negedge clk);

    // R10 soft reset keeps the count and blocks writes and ticks
    set64(64'h0000_ABCD_0000_1234);
    @(negedge clk); soft_rst_n = 1'b0;
    reg_wr = 1'b1; reg_num = 10'd284; reg_wdata = 32'h9; super_mode = 1'b1;
    tick_src_a = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; super_mode = 1'b0;
    repeat (3) @(negedge clk);
    tick_src_a = 1'b0;
    check(priv_viol === 1'b0 && lo_wrap === 1'b0, "R10 outputs in reset", {62'h0, priv_viol, lo_wrap}, 64'h0);
    @(negedge clk); soft_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(268, 32'h0000_1234, "R10 low kept");
    rd(269, 32'h0000_ABCD, "R10 high kept");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R6 scoreboard drained", 64'(sb_q.size()), 64'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule